// File: doc/BRIEF.md
# Serial Port FIFO Level Flags

This block holds the byte FIFOs that sit between a host register port and the line side of a serial port. The host writes transmit bytes into a 16-byte transmit FIFO and reads received bytes out of a 16-byte receive FIFO. Simple byte-wide pop and push ports take the place of the serial shifters. The line side drains the transmit FIFO and fills the receive FIFO through these ports.

Two level flags tell the host when to act. The transmit room flag reports that the transmit FIFO has drained to or below a chosen trigger level. The receive data flag reports that the receive FIFO has filled to or beyond a chosen trigger level. Both flags are sticky. Software clears a flag by reading it as 1 and then writing a 0 to that bit. The flag checks its level condition again on the next clock, so a clear made while the level still holds lasts only one cycle.

The host port has four word addresses. Address 0 is the data register: a write pushes the transmit FIFO and a read pops the receive FIFO. Address 1 is status, with the receive data flag in bit 0 and the transmit room flag in bit 1. Address 2 is FIFO control, with the transmit trigger select in bits [1:0] and the receive trigger select in bits [3:2]. Address 3 is the count register. Host reads are combinational and appear in the same cycle. Writes take effect at the next rising edge.

Top module: `uart_fifo_flags`

## Requirements
- R1: After reset the transmit room flag is 1, the receive data flag is 0, both FIFO counts are 0 and the control register reads 0.
- R2: Host writes to address 0 enter the transmit FIFO and leave on `tx_byte` in write order. A write while 16 bytes are held is dropped and the count stays 16.
- R3: Bytes pushed on `rx_byte` are read from address 0 in arrival order. A push while 16 bytes are held is dropped. A read from an empty receive FIFO returns the last byte read and leaves the count at 0.
- R4: A read of address 3 returns the transmit byte count, zero-extended, in bits [15:8] and the receive byte count, zero-extended, in bits [7:0].
- R5: Control bits [1:0] set the transmit trigger: 0 selects 8 bytes, 1 selects 4, 2 selects 2 and 3 selects 0. The transmit room flag (status bit 1) sets one cycle after the transmit count is at or below the trigger.
- R6: Control bits [3:2] set the receive trigger: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14. The receive data flag (status bit 0) sets one cycle after the receive count is at or above the trigger.
- R7: A status write with a flag's bit at 0 clears that flag only if a status read saw the flag at 1 since the last status write. Otherwise the write has no effect on the flag.
- R8: After a valid clear the flag reads 0 for one cycle. It returns to 1 on the next edge if its level condition still holds, and stays 0 otherwise.
- R9: A set flag stays 1 when its level condition stops holding, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (a read of address 0 pops the receive FIFO; a read of address 1 arms the clear) |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 count |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for `host_addr` |
| tx_pop | input | 1 | Line side takes the head byte of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO is not empty |
| tx_byte | output | 8 | Head byte of the transmit FIFO |
| rx_push | input | 1 | Line side delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_flag | output | 1 | Transmit room flag |
| rx_flag | output | 1 | Receive data flag |

## Verification
Read data and `tx_byte` are combinational, so the bench samples them just after it drives the strobe and before the edge that acts on it. FIFO counts change at the edge that takes a push or pop. A flag follows the count one edge later, and a clear shows at the edge that takes the status write. The bench drives every input on the falling edge and samples 1 ns after a rising edge. When it checks a level flag after a count change, it waits exactly one more edge. It reads a cleared flag right after the clearing edge and again one edge later, which separates the one-cycle dip from a clear that stays.

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        tx_pop,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic        tx_flag,
  output logic        rx_flag
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2, A_CNT = 2'd3;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_trig, rx_trig;
  logic [3:0]    ctrl;
  logic [7:0]    rx_last;
  logic          tdfe, rdf, tx_arm, rx_arm;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire tx_put  = host_wr && host_addr == A_DATA && tx_cnt < FULL;
  wire tx_take = tx_pop && tx_cnt != '0;
  wire rx_put  = rx_push && rx_cnt < FULL;
  wire rx_take = host_rd && host_addr == A_DATA && rx_cnt != '0;
  wire st_rd   = host_rd && host_addr == A_STAT;
  wire st_wr   = host_wr && host_addr == A_STAT;
  wire tx_clr  = st_wr && tx_arm && !host_wdata[1];
  wire rx_clr  = st_wr && rx_arm && !host_wdata[0];

  always_comb begin
    case (ctrl[1:0])
      2'd0:    tx_trig = CW'(8);
      2'd1:    tx_trig = CW'(4);
      2'd2:    tx_trig = CW'(2);
      default: tx_trig = CW'(0);
    endcase
    case (ctrl[3:2])
      2'd0:    rx_trig = CW'(1);
      2'd1:    rx_trig = CW'(4);
      2'd2:    rx_trig = CW'(8);
      default: rx_trig = CW'(14);
    endcase
  end

  wire tx_hit = tx_cnt <= tx_trig;
  wire rx_hit = rx_cnt >= rx_trig;

  always_ff @(posedge clk) begin
    if (tx_put) tx_mem[tx_wp] <= host_wdata[7:0];
    if (rx_put) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_last <= '0;
    end else begin
      if (tx_put)  tx_wp <= bump(tx_wp);
      if (tx_take) tx_rp <= bump(tx_rp);
      if (tx_put && !tx_take) tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_put && tx_take) tx_cnt <= tx_cnt - 1'b1;
      if (rx_put)  rx_wp <= bump(rx_wp);
      if (rx_take) begin
        rx_rp   <= bump(rx_rp);
        rx_last <= rx_mem[rx_rp];
      end
      if (rx_put && !rx_take) rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_put && rx_take) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; tdfe <= 1'b1; rdf <= 1'b0; tx_arm <= 1'b0; rx_arm <= 1'b0;
    end else begin
      if (host_wr && host_addr == A_CTRL) ctrl <= host_wdata[3:0];
      tdfe <= tx_clr ? 1'b0 : (tdfe | tx_hit);
      rdf  <= rx_clr ? 1'b0 : (rdf | rx_hit);
      if (st_wr) begin
        tx_arm <= 1'b0;
        rx_arm <= 1'b0;
      end else if (st_rd) begin
        if (tdfe) tx_arm <= 1'b1;
        if (rdf)  rx_arm <= 1'b1;
      end
    end
  end

  always_comb begin
    case (host_addr)
      A_DATA:  host_rdata = {8'h00, (rx_cnt != '0) ? rx_mem[rx_rp] : rx_last};
      A_STAT:  host_rdata = {14'b0, tdfe, rdf};
      A_CTRL:  host_rdata = {12'b0, ctrl};
      default: host_rdata = {8'(tx_cnt), 8'(rx_cnt)};
    endcase
  end

  assign tx_valid = tx_cnt != '0;
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_flag  = tdfe;
  assign rx_flag  = rdf;

  assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);
  assert_tx_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_DATA && tx_cnt == FULL && !tx_pop) |=> tx_cnt == FULL);
  assert_rx_empty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_DATA && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);
  assert_tx_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= tx_trig && !st_wr) |=> tx_flag);
  assert_rx_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= rx_trig && !st_wr) |=> rx_flag);
  assert_clear_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flag) |-> ($past(tx_arm) && $past(st_wr) && !$past(host_wdata[1])));
  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_flag && rx_cnt >= rx_trig && !st_wr) |=> rx_flag);
  assert_tx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag && !st_wr) |=> tx_flag);
  assert_rx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !st_wr) |=> rx_flag);
endmodule

// File: tb/tb_uart_fifo_flags.sv
module tb_uart_fifo_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        tx_pop = 1'b0, tx_valid;
  logic [7:0]  tx_byte;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_flag, rx_flag;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  uart_fifo_flags dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_flag(tx_flag), .rx_flag(rx_flag)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hwrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic hread(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic lpush(logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(posedge clk); #1 rx_push = 1'b0;
  endtask

  task automatic lpop(output logic [7:0] b);
    @(negedge clk);
    tx_pop = 1'b1;
    #1 b = tx_byte;
    @(posedge clk); #1 tx_pop = 1'b0;
  endtask

  task automatic clear_flag(logic [15:0] wval);
    logic [15:0] s;
    hread(2'd1, s);
    hwrite(2'd1, wval);
  endtask

  task automatic drain_tx();
    logic [15:0] c;
    logic [7:0] b;
    hread(2'd3, c);
    for (int i = 0; i < int'(c[15:8]); i++) lpop(b);
  endtask

  task automatic drain_rx();
    logic [15:0] c, d;
    hread(2'd3, c);
    for (int i = 0; i < int'(c[7:0]); i++) hread(2'd0, d);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 tx flag", tx_flag, 1);
    check("R1 rx flag", rx_flag, 0);
    hread(2'd3, d); check("R1 counts", d, 16'h0000);
    hread(2'd2, d); check("R1 control", d, 16'h0000);
  endtask

  task automatic t_tx_order();
    logic [15:0] d;
    logic [7:0] b;
    hwrite(2'd0, 16'h00A1); hwrite(2'd0, 16'h00A2); hwrite(2'd0, 16'h00A3);
    hread(2'd3, d); check("R4 tx count in upper byte", d, 16'h0300);
    lpop(b); check("R2 order 0", b, 8'hA1);
    lpop(b); check("R2 order 1", b, 8'hA2);
    lpop(b); check("R2 order 2", b, 8'hA3);
    for (int i = 0; i < 17; i++) hwrite(2'd0, 16'(8'h40 + i));
    hread(2'd3, d); check("R2 full write dropped", d, 16'h1000);
    for (int i = 0; i < 16; i++) begin
      lpop(b); check("R2 full order", b, 8'(8'h40 + i));
    end
    check("R2 empty after drain", tx_valid, 0);
  endtask

  task automatic t_rx_order();
    logic [15:0] d;
    lpush(8'h5A); lpush(8'h5B); lpush(8'h5C);
    hread(2'd3, d); check("R4 rx count in lower byte", d, 16'h0003);
    hread(2'd0, d); check("R3 order 0", d, 16'h005A);
    hread(2'd0, d); check("R3 order 1", d, 16'h005B);
    hread(2'd0, d); check("R3 order 2", d, 16'h005C);
    hread(2'd0, d); check("R3 empty read keeps last", d, 16'h005C);
    hread(2'd3, d); check("R3 empty read count", d, 16'h0000);
    for (int i = 0; i < 17; i++) lpush(8'(8'h80 + i));
    hread(2'd3, d); check("R3 full push dropped", d, 16'h0010);
    for (int i = 0; i < 16; i++) begin
      hread(2'd0, d); check("R3 full order", d, 16'(8'h80 + i));
    end
  endtask

  task automatic t_clear_rules();
    logic [7:0] b;
    hwrite(2'd2, 16'h0000);
    for (int i = 0; i < 9; i++) hwrite(2'd0, 16'h0011);
    idle(2); check("R9 tx flag stays above trigger", tx_flag, 1);
    hwrite(2'd1, 16'h0000);
    idle(2); check("R7 unarmed clear ignored", tx_flag, 1);
    clear_flag(16'h0001);
    check("R8 tx clear takes effect", tx_flag, 0);
    idle(3); check("R8 tx stays clear above trigger", tx_flag, 0);
    lpop(b);
    idle(1); check("R5 trigger 8 reached", tx_flag, 1);
    drain_tx();
    clear_flag(16'h0001);
    check("R8 one-cycle dip", tx_flag, 0);
    idle(1); check("R8 flag returns at level", tx_flag, 1);
  endtask

  task automatic t_tx_trig(logic [1:0] sel, int trig);
    logic [7:0] b;
    drain_tx();
    hwrite(2'd2, {14'b0, sel});
    for (int i = 0; i <= trig; i++) hwrite(2'd0, 16'h0022);
    clear_flag(16'h0001);
    idle(2); check("R5 above trigger stays clear", tx_flag, 0);
    lpop(b);
    idle(1); check("R5 sets at trigger", tx_flag, 1);
  endtask

  task automatic t_rx_trig(logic [1:0] sel, int trig);
    logic [15:0] d;
    drain_rx();
    hwrite(2'd2, {12'b0, sel, 2'b00});
    clear_flag(16'h0002);
    idle(2); check("R6 empty rx clear", rx_flag, 0);
    for (int i = 0; i < trig - 1; i++) lpush(8'h33);
    idle(2); check("R6 below trigger", rx_flag, 0);
    lpush(8'h34);
    idle(1); check("R6 sets at trigger", rx_flag, 1);
    hread(2'd0, d);
    idle(2); check("R9 rx flag sticky below trigger", rx_flag, 1);
    clear_flag(16'h0002);
    idle(2); check("R8 rx clear below trigger stays", rx_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_tx_order();
    t_rx_order();
    t_clear_rules();
    t_tx_trig(2'd1, 4);
    t_tx_trig(2'd2, 2);
    t_tx_trig(2'd3, 0);
    t_rx_trig(2'd0, 1);
    t_rx_trig(2'd1, 4);
    t_rx_trig(2'd2, 8);
    t_rx_trig(2'd3, 14);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule